// File: doc/BRIEF.md
# Line-Based Next Fetch Predictor

This block picks the next fetch address in the same cycle that the current fetch address is presented, with no wait for the instructions to be decoded. It holds a small table with one entry per cache-line set. Each entry stores a partial tag, one direction bit for every instruction slot in the line, and one taken-target address for every slot. All slots of the addressed entry are read at once. The predecode bits of the fetched line mark which slots hold branches. A priority scan then finds the lowest slot, at or after the fetch offset, that is both a branch and predicted taken.

When a taken slot is found, that slot's stored target becomes the next fetch address. When none is found, fetch continues at the start of the next sequential line. The block also reports the chosen slot and a mask of the slots in the current group that the front end should keep.

A resolution port trains the table. A taken outcome stores the slot's target and sets its direction bit, and it claims the entry if the tag does not match. A not-taken outcome clears the direction bit of a matching entry.

Top module: `line_next_fetch_pred`

## Requirements
- R1: After reset, every slot of every entry predicts not-taken, so `takenValid` is 0 for any fetch address.
- R2: With no qualifying taken slot, `nextPc` equals `fetchPc` with its low log2(SLOTS*INST_BYTES) bits cleared, plus SLOTS*INST_BYTES. This also holds when the fetch enters mid-line.
- R3: Several slots may qualify: a slot qualifies when it is a branch, its direction bit is set and the tag matches. The lowest-numbered qualifying slot at or after the offset wins. `nextPc` is then that slot's stored target and `takenValid` is 1.
- R4: Slots whose index is below the fetch offset (`fetchPc` bits [BYTE_OFF +: log2(SLOTS)]) never redirect fetch.
- R5: A slot whose `predecodeMask` bit is 0 is never treated as taken, whatever its stored direction bit.
- R6: When the stored partial tag differs from the tag bits of `fetchPc`, all slots are treated as not-taken.
- R7: `keepMask` bit s is 1 exactly when s is at or after the fetch offset and, if `takenValid` is 1, s is at or below `takenSlot`.
- R8: An update with `updTaken`=1 makes the slot addressed by `updPc` predict taken to `updTarget` from the next cycle on. An update with `updTaken`=0 to a matching entry makes that slot not-taken.
- R9: A fetch of the same line in the cycle an update is presented observes the table contents from before the update.
- R10: A taken update whose tag mismatches the entry writes the new tag and leaves every other slot of that entry not-taken.
- R11: `takenSlot` gives the index of the chosen slot when `takenValid` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | ADDR_W | Current fetch address |
| predecodeMask | input | SLOTS | Branch predecode bit per slot of the fetched line |
| updValid | input | 1 | Resolution update strobe |
| updPc | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved direction |
| updTarget | input | ADDR_W | Resolved taken target |
| nextPc | output | ADDR_W | Predicted next fetch address |
| takenValid | output | 1 | A taken slot was chosen |
| takenSlot | output | log2(SLOTS) | Index of the chosen slot |
| keepMask | output | SLOTS | Slots of the current group to keep |

## Verification
The bench builds the block with ADDR_W=16, four slots of four bytes, four sets and a 4-bit tag. With these values, addresses 0x0100 and 0x0140 share set 0 but carry different tags. That puts tag mismatch and the claiming of an entry by a conflicting line within reach of a few directed updates. Four slots are enough to place two taken branches in one line and enter the line at every offset, which exercises the lowest-slot priority, the skipping of earlier slots and the last-slot fall-through.

// File: rtl/nfp_pkg.sv
package nfp_pkg;
  typedef struct packed {
    logic wrEn;      // write the entry this cycle
    logic wrTarget;  // store the target of the addressed slot
    logic alloc;     // replace tag, clear all other direction bits
  } nfpStrobes_t;
endpackage

// File: rtl/nfp_ctrl.sv
module nfp_ctrl
  import nfp_pkg::*;
(
  input  logic        updValid,
  input  logic        updTaken,
  input  logic        updTagHit,
  output nfpStrobes_t strobes
);
  always_comb begin
    strobes.wrEn     = updValid && (updTaken || updTagHit);
    strobes.wrTarget = updValid && updTaken;
    strobes.alloc    = updValid && updTaken && !updTagHit;
  end
endmodule

// File: rtl/nfp_datapath.sv
module nfp_datapath
  import nfp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SLOTS      = 4,
  parameter int INST_BYTES = 4,
  parameter int SETS       = 16,
  parameter int TAG_W      = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         fetchPc,
  input  logic [SLOTS-1:0]          predecodeMask,
  input  logic [ADDR_W-1:0]         updPc,
  input  logic                      updTaken,
  input  logic [ADDR_W-1:0]         updTarget,
  input  nfpStrobes_t               strobes,
  output logic                      updTagHit,
  output logic [ADDR_W-1:0]         nextPc,
  output logic                      takenValid,
  output logic [$clog2(SLOTS)-1:0]  takenSlot,
  output logic [SLOTS-1:0]          keepMask
);
  localparam int OFF_W      = $clog2(SLOTS);
  localparam int BYTE_OFF   = $clog2(INST_BYTES);
  localparam int LINE_LSB   = OFF_W + BYTE_OFF;
  localparam int IDX_W      = $clog2(SETS);
  localparam int LINE_BYTES = SLOTS * INST_BYTES;

  logic [TAG_W-1:0]  tagMem [SETS];
  logic [SLOTS-1:0]  dirMem [SETS];
  logic [ADDR_W-1:0] tgtMem [SETS][SLOTS];

  // fetch side fields
  logic [IDX_W-1:0] rdIdx;
  logic [TAG_W-1:0] rdTag;
  logic [OFF_W-1:0] rdOff;
  logic             rdHit;
  logic [SLOTS-1:0] qualMask;

  assign rdIdx = fetchPc[LINE_LSB +: IDX_W];
  assign rdTag = fetchPc[LINE_LSB+IDX_W +: TAG_W];
  assign rdOff = fetchPc[BYTE_OFF +: OFF_W];
  assign rdHit = (tagMem[rdIdx] == rdTag);

  genvar gs;
  generate
    for (gs = 0; gs < SLOTS; gs++) begin : g_qual
      assign qualMask[gs] = rdHit && dirMem[rdIdx][gs] && predecodeMask[gs]
                            && (OFF_W'(gs) >= rdOff);
    end
  endgenerate

  // priority scan: lowest qualifying slot
  always_comb begin
    takenValid = 1'b0;
    takenSlot  = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (qualMask[s]) begin
        takenValid = 1'b1;
        takenSlot  = OFF_W'(s);
      end
    end
  end

  logic [ADDR_W-1:0] lineBase;
  assign lineBase = {fetchPc[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};

  always_comb begin
    if (takenValid) nextPc = tgtMem[rdIdx][takenSlot];
    else            nextPc = lineBase + ADDR_W'(LINE_BYTES);
  end

  generate
    for (gs = 0; gs < SLOTS; gs++) begin : g_keep
      assign keepMask[gs] = (OFF_W'(gs) >= rdOff) &&
                            (!takenValid || OFF_W'(gs) <= takenSlot);
    end
  endgenerate

  // update side fields
  logic [IDX_W-1:0] wrIdx;
  logic [TAG_W-1:0] wrTag;
  logic [OFF_W-1:0] wrSlot;
  logic             unusedUpd;

  assign wrIdx     = updPc[LINE_LSB +: IDX_W];
  assign wrTag     = updPc[LINE_LSB+IDX_W +: TAG_W];
  assign wrSlot    = updPc[BYTE_OFF +: OFF_W];
  assign updTagHit = (tagMem[wrIdx] == wrTag);
  assign unusedUpd = ^updPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SETS; i++) begin
        tagMem[i] <= '0;
        dirMem[i] <= '0;
      end
    end else if (strobes.wrEn) begin
      if (strobes.alloc) begin
        tagMem[wrIdx] <= wrTag;
        dirMem[wrIdx] <= SLOTS'(1) << wrSlot;
      end else begin
        dirMem[wrIdx][wrSlot] <= updTaken;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrTarget) tgtMem[wrIdx][wrSlot] <= updTarget;
  end
endmodule

// File: rtl/line_next_fetch_pred.sv
module line_next_fetch_pred
  import nfp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SLOTS      = 4,
  parameter int INST_BYTES = 4,
  parameter int SETS       = 16,
  parameter int TAG_W      = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         fetchPc,
  input  logic [SLOTS-1:0]          predecodeMask,
  input  logic                      updValid,
  input  logic [ADDR_W-1:0]         updPc,
  input  logic                      updTaken,
  input  logic [ADDR_W-1:0]         updTarget,
  output logic [ADDR_W-1:0]         nextPc,
  output logic                      takenValid,
  output logic [$clog2(SLOTS)-1:0]  takenSlot,
  output logic [SLOTS-1:0]          keepMask
);
  nfpStrobes_t strobes;
  logic        updTagHit;

  nfp_ctrl u_ctrl (
    .updValid  (updValid),
    .updTaken  (updTaken),
    .updTagHit (updTagHit),
    .strobes   (strobes)
  );

  nfp_datapath #(
    .ADDR_W(ADDR_W), .SLOTS(SLOTS), .INST_BYTES(INST_BYTES),
    .SETS(SETS), .TAG_W(TAG_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .fetchPc       (fetchPc),
    .predecodeMask (predecodeMask),
    .updPc         (updPc),
    .updTaken      (updTaken),
    .updTarget     (updTarget),
    .strobes       (strobes),
    .updTagHit     (updTagHit),
    .nextPc        (nextPc),
    .takenValid    (takenValid),
    .takenSlot     (takenSlot),
    .keepMask      (keepMask)
  );
endmodule

// File: rtl/nfp_checker.sv
module nfp_checker #(
  parameter int ADDR_W     = 32,
  parameter int SLOTS      = 4,
  parameter int INST_BYTES = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [ADDR_W-1:0]        fetchPc,
  input logic [SLOTS-1:0]         predecodeMask,
  input logic                     updValid,
  input logic [ADDR_W-1:0]        updPc,
  input logic                     updTaken,
  input logic [ADDR_W-1:0]        updTarget,
  input logic [ADDR_W-1:0]        nextPc,
  input logic                     takenValid,
  input logic [$clog2(SLOTS)-1:0] takenSlot,
  input logic [SLOTS-1:0]         keepMask
);
  localparam int OFF_W      = $clog2(SLOTS);
  localparam int BYTE_OFF   = $clog2(INST_BYTES);
  localparam int LINE_LSB   = OFF_W + BYTE_OFF;
  localparam int LINE_BYTES = SLOTS * INST_BYTES;

  logic [OFF_W-1:0]  chkOff;
  logic [OFF_W-1:0]  chkUpdSlot;
  logic [ADDR_W-1:0] chkFall;
  assign chkOff     = fetchPc[BYTE_OFF +: OFF_W];
  assign chkUpdSlot = updPc[BYTE_OFF +: OFF_W];
  assign chkFall    = {fetchPc[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}} + ADDR_W'(LINE_BYTES);

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !takenValid |-> nextPc == chkFall);  // R2

  AST_NOT_BEFORE_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    takenValid |-> takenSlot >= chkOff);  // R4

  AST_BRANCH_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    takenValid |-> predecodeMask[takenSlot]);  // R5

  AST_KEEP_ENDS_AT_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    takenValid |-> (keepMask[takenSlot] && ((keepMask >> takenSlot) >> 1) == '0));  // R7

  AST_KEEP_HAS_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    keepMask[chkOff]);  // R7

  AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !takenValid |-> takenSlot == '0);  // R11

  AST_UPDATE_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(updValid && updTaken) && fetchPc == $past(updPc)
     && predecodeMask[$past(chkUpdSlot)])
    |-> (takenValid && takenSlot == $past(chkUpdSlot) && nextPc == $past(updTarget)));  // R8

  logic unusedChk;
  assign unusedChk = ^{updTarget, updPc};
endmodule

bind line_next_fetch_pred nfp_checker #(
  .ADDR_W(ADDR_W), .SLOTS(SLOTS), .INST_BYTES(INST_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predecodeMask(predecodeMask),
  .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget),
  .nextPc(nextPc), .takenValid(takenValid), .takenSlot(takenSlot), .keepMask(keepMask)
);

// File: tb/line_next_fetch_pred_tb.sv
module line_next_fetch_pred_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int SLOTS  = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] fetchPc;
  logic [SLOTS-1:0]  predecodeMask;
  logic              updValid;
  logic [ADDR_W-1:0] updPc;
  logic              updTaken;
  logic [ADDR_W-1:0] updTarget;
  logic [ADDR_W-1:0] nextPc;
  logic              takenValid;
  logic [1:0]        takenSlot;
  logic [SLOTS-1:0]  keepMask;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_next_fetch_pred #(
    .ADDR_W(ADDR_W), .SLOTS(SLOTS), .INST_BYTES(4), .SETS(4), .TAG_W(4)
  ) u_dut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predecodeMask(predecodeMask),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget),
    .nextPc(nextPc), .takenValid(takenValid), .takenSlot(takenSlot), .keepMask(keepMask)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic look(logic [ADDR_W-1:0] pc, logic [SLOTS-1:0] pd);
    fetchPc = pc;
    predecodeMask = pd;
    #1;
  endtask

  task automatic expectOut(string req, int npc, int tv, int slot, int keep);
    chk({req, " nextPc"}, int'(nextPc), npc);
    chk({req, " takenValid"}, int'(takenValid), tv);
    chk({req, " takenSlot"}, int'(takenSlot), slot);
    chk({req, " keepMask"}, int'(keepMask), keep);
  endtask

  // drive update after a falling edge, hold through one rising edge
  task automatic update(logic [ADDR_W-1:0] pc, logic tk, logic [ADDR_W-1:0] tgt);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = tk; updTarget = tgt;
    @(posedge clk);
    #1;
    updValid = 1'b0;
  endtask

  task automatic t_reset;
    look(16'h0104, 4'b1111);
    expectOut("R1 R2 R7 reset mid-line", 16'h0110, 0, 0, 4'b1110);
    look(16'h0100, 4'b1111);
    expectOut("R1 R11 reset line start", 16'h0110, 0, 0, 4'b1111);
  endtask

  task automatic t_firstTaken;
    @(negedge clk);
    look(16'h0100, 4'b1111);
    updValid = 1'b1; updPc = 16'h0108; updTaken = 1'b1; updTarget = 16'h0400;
    #1;
    expectOut("R9 same-cycle old value", 16'h0110, 0, 0, 4'b1111);
    @(posedge clk);
    #1;
    updValid = 1'b0;
    #1;
    expectOut("R3 R8 taken slot2", 16'h0400, 1, 2, 4'b0111);
  endtask

  task automatic t_priority;
    update(16'h0104, 1'b1, 16'h0200);
    look(16'h0100, 4'b1111);
    expectOut("R3 lowest slot wins", 16'h0200, 1, 1, 4'b0011);
    look(16'h0108, 4'b1111);
    expectOut("R4 earlier slot skipped", 16'h0400, 1, 2, 4'b0100);
    look(16'h010C, 4'b1111);
    expectOut("R4 R2 last slot fall-through", 16'h0110, 0, 0, 4'b1000);
  endtask

  task automatic t_predecode;
    look(16'h0100, 4'b1101);
    expectOut("R5 non-branch slot1 skipped", 16'h0400, 1, 2, 4'b0111);
    look(16'h0100, 4'b0000);
    expectOut("R5 no branches", 16'h0110, 0, 0, 4'b1111);
  endtask

  task automatic t_tagMiss;
    look(16'h0140, 4'b1111);
    expectOut("R6 tag mismatch", 16'h0150, 0, 0, 4'b1111);
  endtask

  task automatic t_notTaken;
    update(16'h0104, 1'b0, 16'h0000);
    look(16'h0100, 4'b1111);
    expectOut("R8 not-taken clears slot1", 16'h0400, 1, 2, 4'b0111);
  endtask

  task automatic t_alloc;
    update(16'h0144, 1'b1, 16'h0800);
    look(16'h0140, 4'b1111);
    expectOut("R10 R8 new line taken", 16'h0800, 1, 1, 4'b0011);
    look(16'h0148, 4'b1111);
    expectOut("R10 other slots cleared", 16'h0150, 0, 0, 4'b1100);
    look(16'h0100, 4'b1111);
    expectOut("R6 old line now misses", 16'h0110, 0, 0, 4'b1111);
  endtask

  initial begin
    rstN = 1'b0; fetchPc = '0; predecodeMask = '0;
    updValid = 1'b0; updPc = '0; updTaken = 1'b0; updTarget = '0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_firstTaken();
    t_priority();
    t_predecode();
    t_tagMiss();
    t_notTaken();
    t_alloc();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule